// File: doc/BRIEF.md
# Minimal 8-bit Stack Processor Core

A small multi-cycle 8-bit processor. Code and stack share one 256-byte memory, and there are eight 8-bit general registers, the last of which is the stack pointer. The core reads a one-byte opcode and then up to two operand bytes. It executes six instructions: halt, load immediate, print register, multiply, push and pop. An instruction is 1, 2 or 3 bytes long.

A host fills memory through a byte-wide loader port while it holds the core in synchronous reset. When reset is released, execution starts at address 0. A print instruction places a register value on an 8-bit output with a one-cycle strobe. A halt instruction stops the core and leaves `halted` high. An unrecognised opcode does the same and also raises `illegal_op`. Both flags hold until the next reset.

Top module: `stack_cpu8`

## Requirements
- R1: While `rst` is high (active-high, synchronous): the program counter is 0, registers 0..6 are 0x00, register 7 is 0xF4, and `out_valid`, `halted` and `illegal_op` are low.
- R2: `load_en` writes `load_data` to memory address `load_addr` on a rising edge only while `rst` is high. While the core runs, the loader port has no effect on memory.
- R3: The opcode is the byte at PC. Operand A is at PC+1 and operand B is at PC+2, with addresses wrapping modulo 256. When an operand names a register, only its low 3 bits select the register.
- R4: Opcode 0x82 (load immediate) writes operand B into register A and advances PC by 3. It takes 5 cycles.
- R5: Opcode 0x47 (print) drives register A onto `out_data`, with `out_valid` high for exactly one cycle. It advances PC by 2 and takes 4 cycles. The strobe is visible after the 4th rising edge counted from the start of the instruction.
- R6: Opcode 0xA2 (multiply) writes the low 8 bits of register A times register B into register A. It advances PC by 3 and takes 5 cycles.
- R7: Opcode 0x45 (push) first decrements register 7, then writes register A to memory at the new register 7 value. For A = 7, the stored value is the already decremented pointer. Push advances PC by 2 and takes 4 cycles.
- R8: Opcode 0x46 (pop) loads register A from memory at register 7, then increments register 7. For A = 7, register 7 ends as the loaded byte plus 1. Pop advances PC by 2 and takes 5 cycles.
- R9: Opcode 0x01 (halt) sets `halted` on the 2nd rising edge after the instruction starts. `halted` stays high until reset, and no further strobe appears.
- R10: Any opcode other than the six listed sets both `halted` and `illegal_op` on the 2nd rising edge after the instruction starts. Both stay high until reset.
- R11: Register 7 wraps modulo 256: push from 0x00 gives 0xFF, and pop from 0xFF gives 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loader window |
| load_en | input | 1 | Loader write enable (effective only in reset) |
| load_addr | input | 8 | Loader byte address |
| load_data | input | 8 | Loader byte value |
| out_data | output | 8 | Printed register value |
| out_valid | output | 1 | One-cycle strobe for `out_data` |
| halted | output | 1 | Core stopped (halt or illegal opcode) |
| illegal_op | output | 1 | Core stopped on an unknown opcode |

## Verification
Each instruction has a fixed length in cycles: 5 for load immediate, multiply and pop, 4 for print and push, and 2 until halt or an illegal stop shows on the flags. A print strobe therefore appears exactly 4 edges after its instruction begins. The bench model runs each program and turns these lengths into an absolute cycle number for every strobe and for the flag rise. On every clock after reset release, the bench compares the strobe, the data and both flags against those predicted cycles, so a result that comes one cycle early or late fails. The same per-cycle comparison checks that an ignored loader write leaves later instructions unchanged.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  localparam logic [7:0] OPC_HALT = 8'h01;
  localparam logic [7:0] OPC_LDI  = 8'h82;
  localparam logic [7:0] OPC_PRN  = 8'h47;
  localparam logic [7:0] OPC_MUL  = 8'hA2;
  localparam logic [7:0] OPC_PUSH = 8'h45;
  localparam logic [7:0] OPC_POP  = 8'h46;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_OPA,
    ST_OPB,
    ST_OPC,
    ST_EXEC,
    ST_POPWB,
    ST_STOP
  } seq_state_t;

endpackage

// File: rtl/cpu8_mem.sv
module cpu8_mem #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter int             DW      = 8,
  parameter int             NREG    = 8,
  parameter logic [DW-1:0]  SP_INIT = 8'hF4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NREG)-1:0] ra,
  input  logic [$clog2(NREG)-1:0] rb,
  output logic [DW-1:0]           rdata_a,
  output logic [DW-1:0]           rdata_b,
  output logic [DW-1:0]           sp,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DW-1:0]           wdata,
  input  logic                    sp_we,
  input  logic [DW-1:0]           sp_wdata
);
  localparam int SP_IDX = NREG - 1;

  logic [DW-1:0] regs [NREG];

  // the general write port is applied last, so it wins over the pointer port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == SP_IDX) ? SP_INIT : '0;
    end else begin
      if (sp_we) regs[SP_IDX] <= sp_wdata;
      if (we)    regs[waddr]  <= wdata;
    end
  end

  assign rdata_a = regs[ra];
  assign rdata_b = regs[rb];
  assign sp      = regs[SP_IDX];
endmodule

// File: rtl/cpu8_seq.sv
module cpu8_seq
  import cpu8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DW-1:0]           mem_rdata,
  output logic [DW-1:0]           mem_raddr,
  output logic                    mem_we,
  output logic [DW-1:0]           mem_waddr,
  output logic [DW-1:0]           mem_wdata,
  output logic [$clog2(NREG)-1:0] rf_ra,
  output logic [$clog2(NREG)-1:0] rf_rb,
  input  logic [DW-1:0]           rf_rdata_a,
  input  logic [DW-1:0]           rf_rdata_b,
  input  logic [DW-1:0]           rf_sp,
  output logic                    rf_we,
  output logic [$clog2(NREG)-1:0] rf_waddr,
  output logic [DW-1:0]           rf_wdata,
  output logic                    sp_we,
  output logic [DW-1:0]           sp_wdata,
  output logic [DW-1:0]           out_data,
  output logic                    out_valid,
  output logic                    halted,
  output logic                    illegal_op
);
  localparam int                 AW     = DW;
  localparam int                 RIW    = $clog2(NREG);
  localparam logic [RIW-1:0]     SP_IDX = RIW'(NREG - 1);

  seq_state_t     state;
  logic [AW-1:0]  pc;
  logic [DW-1:0]  opcode;
  logic [RIW-1:0] idx_a, idx_b;
  logic [DW-1:0]  imm_b;
  logic           three_byte, known_op;
  logic [DW-1:0]  sp_dec, sp_inc, prod_lo;

  assign three_byte = (opcode == OPC_LDI) || (opcode == OPC_MUL);
  assign known_op   = (mem_rdata == OPC_LDI)  || (mem_rdata == OPC_PRN) ||
                      (mem_rdata == OPC_MUL)  || (mem_rdata == OPC_PUSH) ||
                      (mem_rdata == OPC_POP);
  assign sp_dec     = rf_sp - DW'(1);
  assign sp_inc     = rf_sp + DW'(1);
  assign prod_lo    = rf_rdata_a * rf_rdata_b;
  assign rf_ra      = idx_a;
  assign rf_rb      = idx_b;

  // synchronous-read memory: address is issued one state before the byte is used
  always_comb begin
    case (state)
      ST_OPA:  mem_raddr = pc + AW'(1);
      ST_OPB:  mem_raddr = pc + AW'(2);
      ST_EXEC: mem_raddr = rf_sp;
      default: mem_raddr = pc;
    endcase
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = sp_dec;
    mem_wdata = rf_rdata_a;
    rf_we     = 1'b0;
    rf_waddr  = idx_a;
    rf_wdata  = imm_b;
    sp_we     = 1'b0;
    sp_wdata  = sp_dec;
    if (state == ST_EXEC) begin
      case (opcode)
        OPC_LDI: rf_we = 1'b1;
        OPC_MUL: begin
          rf_we    = 1'b1;
          rf_wdata = prod_lo;
        end
        OPC_PUSH: begin
          sp_we     = 1'b1;
          mem_we    = 1'b1;
          mem_wdata = (idx_a == SP_IDX) ? sp_dec : rf_rdata_a;
        end
        default: ;
      endcase
    end else if (state == ST_POPWB) begin
      rf_we    = 1'b1;
      rf_wdata = (idx_a == SP_IDX) ? mem_rdata + DW'(1) : mem_rdata;
      sp_we    = 1'b1;
      sp_wdata = sp_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_FETCH;
      pc         <= '0;
      opcode     <= '0;
      idx_a      <= '0;
      idx_b      <= '0;
      imm_b      <= '0;
      out_data   <= '0;
      out_valid  <= 1'b0;
      halted     <= 1'b0;
      illegal_op <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_FETCH: state <= ST_OPA;
        ST_OPA: begin
          opcode <= mem_rdata;
          if (mem_rdata == OPC_HALT) begin
            halted <= 1'b1;
            state  <= ST_STOP;
          end else if (known_op) begin
            state <= ST_OPB;
          end else begin
            halted     <= 1'b1;
            illegal_op <= 1'b1;
            state      <= ST_STOP;
          end
        end
        ST_OPB: begin
          idx_a <= mem_rdata[RIW-1:0];
          state <= three_byte ? ST_OPC : ST_EXEC;
        end
        ST_OPC: begin
          idx_b <= mem_rdata[RIW-1:0];
          imm_b <= mem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (opcode == OPC_POP) begin
            state <= ST_POPWB;
          end else begin
            pc    <= pc + (three_byte ? AW'(3) : AW'(2));
            state <= ST_FETCH;
            if (opcode == OPC_PRN) begin
              out_valid <= 1'b1;
              out_data  <= rf_rdata_a;
            end
          end
        end
        ST_POPWB: begin
          pc    <= pc + AW'(2);
          state <= ST_FETCH;
        end
        default: state <= ST_STOP;
      endcase
    end
  end
endmodule

// File: rtl/stack_cpu8.sv
module stack_cpu8 #(
  parameter int            DW      = 8,
  parameter int            NREG    = 8,
  parameter logic [DW-1:0] SP_INIT = 8'hF4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [DW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          halted,
  output logic          illegal_op
);
  localparam int AW  = DW;
  localparam int RIW = $clog2(NREG);

  logic [AW-1:0]  mem_raddr, core_waddr, m_waddr;
  logic [DW-1:0]  mem_rdata, core_wdata, m_wdata;
  logic           core_we, m_we;
  logic [RIW-1:0] rf_ra, rf_rb, rf_waddr;
  logic [DW-1:0]  rf_rdata_a, rf_rdata_b, rf_sp, rf_wdata, sp_wdata;
  logic           rf_we, sp_we;

  // loader owns the write port during reset, the core afterwards
  assign m_we    = rst ? load_en   : core_we;
  assign m_waddr = rst ? load_addr : core_waddr;
  assign m_wdata = rst ? load_data : core_wdata;

  cpu8_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  cpu8_regfile #(.DW(DW), .NREG(NREG), .SP_INIT(SP_INIT)) u_rf (
    .clk(clk), .rst(rst), .ra(rf_ra), .rb(rf_rb),
    .rdata_a(rf_rdata_a), .rdata_b(rf_rdata_b), .sp(rf_sp),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata)
  );

  cpu8_seq #(.DW(DW), .NREG(NREG)) u_seq (
    .clk(clk), .rst(rst),
    .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
    .mem_we(core_we), .mem_waddr(core_waddr), .mem_wdata(core_wdata),
    .rf_ra(rf_ra), .rf_rb(rf_rb),
    .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b), .rf_sp(rf_sp),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata),
    .out_data(out_data), .out_valid(out_valid),
    .halted(halted), .illegal_op(illegal_op)
  );
endmodule

// File: rtl/cpu8_chk.sv
module cpu8_chk (
  input logic clk,
  input logic rst,
  input logic out_valid,
  input logic halted,
  input logic illegal_op
);
  // R5
  prn_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R9
  halt_silent_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !out_valid);

  // R10
  illegal_halts_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> halted);

  // R10
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_op |=> illegal_op);
endmodule

bind stack_cpu8 cpu8_chk u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid),
  .halted(halted), .illegal_op(illegal_op)
);

// File: tb/sim_stack_cpu8.sv
`timescale 1ns/1ps
module sim_stack_cpu8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic [7:0] load_addr = 8'h00;
  logic [7:0] load_data = 8'h00;
  logic [7:0] out_data;
  logic       out_valid, halted, illegal_op;

  always #2 clk = ~clk;

  stack_cpu8 u0 (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .out_data(out_data), .out_valid(out_valid),
    .halted(halted), .illegal_op(illegal_op)
  );

  int         checks = 0;
  int         failures = 0;
  bit         finished = 0;
  logic [7:0] img [256];
  int         exp_cyc [$];
  logic [7:0] exp_val [$];
  string      exp_tag [$];
  int         halt_at;
  bit         exp_ill;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // instruction-level model producing absolute cycle numbers of each event
  task automatic model_run();
    logic [7:0] m [256];
    logic [7:0] r [8];
    string      wt [8];
    logic [7:0] pc, op, a, b, sp_old;
    logic [2:0] ai, bi;
    int         t;
    for (int i = 0; i < 256; i++) m[i] = img[i];
    for (int i = 0; i < 8; i++) begin r[i] = 8'h00; wt[i] = "R1"; end
    r[7] = 8'hF4;
    pc = 8'h00;
    t = 0;
    exp_cyc.delete(); exp_val.delete(); exp_tag.delete();
    halt_at = 1000000; exp_ill = 0;
    for (int step = 0; step < 1000; step++) begin
      op = m[pc]; a = m[pc + 8'd1]; b = m[pc + 8'd2];
      ai = a[2:0]; bi = b[2:0];
      case (op)
        8'h82: begin r[ai] = b; wt[ai] = "R4"; pc = pc + 8'd3; t += 5; end
        8'h47: begin
          exp_cyc.push_back(t + 4);
          exp_val.push_back(r[ai]);
          exp_tag.push_back((a[7:3] != 5'd0) ? "R3" : wt[ai]);
          pc = pc + 8'd2; t += 4;
        end
        8'hA2: begin r[ai] = r[ai] * r[bi]; wt[ai] = "R6"; pc = pc + 8'd3; t += 5; end
        8'h45: begin
          wt[7] = (r[7] == 8'h00) ? "R11" : "R7";
          r[7] = r[7] - 8'd1;
          m[r[7]] = r[ai];
          pc = pc + 8'd2; t += 4;
        end
        8'h46: begin
          sp_old = r[7];
          r[ai] = m[sp_old];
          r[7] = r[7] + 8'd1;
          wt[7] = (sp_old == 8'hFF) ? "R11" : "R8";
          wt[ai] = "R8";
          pc = pc + 8'd2; t += 5;
        end
        8'h01: begin halt_at = t + 2; exp_ill = 0; return; end
        default: begin halt_at = t + 2; exp_ill = 1; return; end
      endcase
    end
  endtask

  task automatic run_prog(input logic [7:0] prog [$], input string cnt_req, input bit poke);
    int qi = 0;
    int seen = 0;
    for (int i = 0; i < 256; i++) img[i] = (i < prog.size()) ? prog[i] : 8'h00;
    model_run();
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      load_en = 1'b1; load_addr = 8'(i); load_data = img[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "halted in reset", int'(halted), 0);
    chk("R1", "illegal_op in reset", int'(illegal_op), 0);
    rst = 1'b0;
    for (int cyc = 0; cyc <= halt_at + 6; cyc++) begin
      if (cyc > 0) begin @(posedge clk); @(negedge clk); end
      if (qi < exp_cyc.size() && exp_cyc[qi] == cyc) begin
        chk("R5", "print strobe", int'(out_valid), 1);
        chk(exp_tag[qi], "print value", int'(out_data), int'(exp_val[qi]));
        qi++;
      end else begin
        chk("R5", "no strobe", int'(out_valid), 0);
      end
      if (out_valid) seen++;
      chk("R9", "halted", int'(halted), int'(cyc >= halt_at));
      chk("R10", "illegal_op", int'(illegal_op), int'(exp_ill && cyc >= halt_at));
      // R2: a write attempted while running must not change the program
      if (poke) begin
        load_en = (cyc == 1);
        load_addr = 8'd5;
        load_data = 8'h01;
      end
    end
    load_en = 1'b0;
    chk(cnt_req, "print count", seen, exp_cyc.size());
  endtask

  initial begin
    logic [7:0] p1 [$];
    logic [7:0] p2 [$];
    logic [7:0] p3 [$];
    // R1 reset values, R4 load, R6 multiply with truncation, R3 high index bits
    p1 = '{8'h47, 8'h07, 8'h47, 8'h00, 8'h82, 8'h00, 8'h08, 8'h47, 8'h00,
           8'h82, 8'h01, 8'h09, 8'hA2, 8'h00, 8'h01, 8'h47, 8'h00,
           8'h82, 8'h02, 8'h14, 8'hA2, 8'h02, 8'h02, 8'h47, 8'h02,
           8'h82, 8'h0B, 8'h5A, 8'h47, 8'h13, 8'h01};
    // R7 push, R8 pop incl. pointer as operand, R11 pointer wrap
    p2 = '{8'h82, 8'h00, 8'h11, 8'h82, 8'h01, 8'h22, 8'h45, 8'h00, 8'h45, 8'h01,
           8'h47, 8'h07, 8'h46, 8'h02, 8'h46, 8'h03, 8'h47, 8'h02, 8'h47, 8'h03,
           8'h47, 8'h07, 8'h45, 8'h07, 8'h46, 8'h04, 8'h47, 8'h04,
           8'h82, 8'h07, 8'h00, 8'h45, 8'h00, 8'h47, 8'h07, 8'h46, 8'h07,
           8'h47, 8'h07, 8'h01};
    // R2 ignored loader write while running, R10 unknown opcode 0x00
    p3 = '{8'h82, 8'h00, 8'h05, 8'h47, 8'h00, 8'h47, 8'h00, 8'h00};
    repeat (2) @(negedge clk);
    run_prog(p1, "R5", 1'b0);
    run_prog(p2, "R7", 1'b0);
    run_prog(p3, "R2", 1'b1);
    report();
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end
endmodule